// File: doc/BRIEF.md
# Sixteen-Level Core Interrupt Arbiter

This block sits in front of a processor core and folds sixteen numbered interrupt levels into a single request. Level 0 carries the reset request and level 1 the non-maskable interrupt. Levels 2 and 3 are reserved and stay inert. Levels 4 through 15 come from sources outside the core. A level that is lower in number always has the higher priority.

Every input line is watched for a rising edge. When an edge arrives, the block remembers it as pending. The pending state stays until the core acknowledges that level or software clears it. A per-level enable mask and a global enable gate the external levels only. The winning level number and a request strobe come out of registers. Software reaches the block through a small register port with four word addresses. Through that port it can read the pending flags, read and write the enables, and set or clear pending flags.

Top module: `cic_core`

## Requirements
- R1: After a synchronous reset, the request output is 0, the level output is 0, and the pending and enable registers both read 0.
- R2: A rising edge on a non-reserved input line sets the pending bit of that level. A line that stays high does not set the bit again after the bit has been cleared.
- R3: Levels 2 and 3 never become pending and are never requested, whatever their input lines do or software writes to them.
- R4: The request names the lowest-numbered eligible pending level. Level 0 therefore beats level 1, and both beat every external level.
- R5: Enable bit n gates external level n, for n from 4 to 15. Enable bits 0 to 3 cannot be written and read as 0. Levels 0 and 1 ignore the mask.
- R6: When the global enable is low, levels 4 to 15 cannot be requested. Levels 0 and 1 are still requested.
- R7: An acknowledge clears only the pending bit of the level number it carries. A rising edge on that same level in the same cycle leaves the bit set.
- R8: The request and level outputs change exactly one clock after the pending state or an enable changes. They do not change in the same cycle.
- R9: The register port has four addresses: 0 reads the pending flags, 1 reads and writes the enables, 2 sets the pending bits written as 1, and 3 clears the pending bits written as 1. Read data appears one clock after the address is presented. A rising edge arriving in the same cycle as a clear write leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Raw interrupt lines, bit n is level n |
| glob_en | input | 1 | Global enable for levels 4 to 15 |
| ack_valid | input | 1 | Acknowledge strobe from the core |
| ack_level | input | 4 | Level number being acknowledged |
| reg_addr | input | 2 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| req_o | output | 1 | Interrupt request to the core |
| req_level_o | output | 4 | Winning level number, 0 when no request |

## Verification
The arbiter is driven with several kinds of input pattern. Single lines show the edge capture and the one-cycle output latency. Pairs of external lines show that the lowest number wins, and changing the mask then moves the winner. The bench raises reset and non-maskable requests while the global enable is low, which shows that the gating stops at level 4. Writes and pulses on the reserved lines must leave no trace. Collisions in one cycle, an acknowledge or a clear write against a fresh edge on the same level, show which of the two wins. A line held high past its acknowledge separates true edge detection from simply following the level.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic [1:0] {
    REG_PEND  = 2'd0,
    REG_EN    = 2'd1,
    REG_SET   = 2'd2,
    REG_CLR   = 2'd3
  } cic_reg_e;

  localparam int unsigned RESET_LVL = 0;
  localparam int unsigned NMI_LVL   = 1;
  localparam int unsigned FIXED_CNT = 2;
endpackage

// File: rtl/cic_edge_detect.sv
module cic_edge_detect #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lines,
  output logic [W-1:0] rise
);
  logic [W-1:0] lines_q;

  always_ff @(posedge clk) begin
    if (rst) lines_q <= '0;
    else     lines_q <= lines;
  end

  assign rise = lines & ~lines_q;
endmodule

// File: rtl/cic_pending.sv
module cic_pending #(
  parameter int unsigned W         = 16,
  parameter int unsigned FIRST_EXT = 4,
  localparam int unsigned LW       = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  rise,
  input  logic [W-1:0]  sw_set,
  input  logic [W-1:0]  sw_clr,
  input  logic          ack_valid,
  input  logic [LW-1:0] ack_level,
  output logic [W-1:0]  pend_q
);
  import cic_pkg::*;

  logic [W-1:0] inert;
  logic [W-1:0] ack_oh;
  logic [W-1:0] pend_d;

  for (genvar i = 0; i < W; i++) begin : g_inert
    if (i >= FIXED_CNT && i < FIRST_EXT) begin : g_rsvd
      assign inert[i] = 1'b1;
    end else begin : g_live
      assign inert[i] = 1'b0;
    end
  end

  assign ack_oh = ack_valid ? (W'(1) << ack_level) : '0;
  assign pend_d = ((pend_q & ~(sw_clr | ack_oh)) | rise | sw_set) & ~inert;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/cic_prio_pick.sv
module cic_prio_pick #(
  parameter int unsigned W  = 16,
  localparam int unsigned LW = $clog2(W)
) (
  input  logic [W-1:0]  elig,
  output logic          found,
  output logic [LW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/cic_core.sv
module cic_core #(
  parameter int unsigned NUM_LVL   = 16,
  parameter int unsigned FIRST_EXT = 4,
  localparam int unsigned LW       = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] irq_lines,
  input  logic               glob_en,
  input  logic               ack_valid,
  input  logic [LW-1:0]      ack_level,
  input  logic [1:0]         reg_addr,
  input  logic               reg_we,
  input  logic [NUM_LVL-1:0] reg_wdata,
  output logic [NUM_LVL-1:0] reg_rdata,
  output logic               req_o,
  output logic [LW-1:0]      req_level_o
);
  import cic_pkg::*;

  logic [NUM_LVL-1:0] rise_vec;
  logic [NUM_LVL-1:0] set_vec;
  logic [NUM_LVL-1:0] clr_vec;
  logic [NUM_LVL-1:0] pend_vec;
  logic [NUM_LVL-1:0] en_q;
  logic [NUM_LVL-1:0] ext_mask;
  logic [NUM_LVL-1:0] fixed_mask;
  logic [NUM_LVL-1:0] elig;
  logic               win_found;
  logic [LW-1:0]      win_idx;

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_masks
    assign ext_mask[i]   = (i >= FIRST_EXT);
    assign fixed_mask[i] = (i < FIXED_CNT);
  end

  cic_edge_detect #(.W(NUM_LVL)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .lines (irq_lines),
    .rise  (rise_vec)
  );

  assign set_vec = (reg_we && reg_addr == REG_SET) ? reg_wdata : '0;
  assign clr_vec = (reg_we && reg_addr == REG_CLR) ? reg_wdata : '0;

  cic_pending #(.W(NUM_LVL), .FIRST_EXT(FIRST_EXT)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise_vec),
    .sw_set    (set_vec),
    .sw_clr    (clr_vec),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .pend_q    (pend_vec)
  );

  always_ff @(posedge clk) begin
    if (rst)                              en_q <= '0;
    else if (reg_we && reg_addr == REG_EN) en_q <= reg_wdata & ext_mask;
  end

  assign elig = pend_vec & (fixed_mask | (glob_en ? en_q : '0));

  cic_prio_pick #(.W(NUM_LVL)) u_pick (
    .elig  (elig),
    .found (win_found),
    .idx   (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o       <= 1'b0;
      req_level_o <= '0;
    end else begin
      req_o       <= win_found;
      req_level_o <= win_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        REG_PEND: reg_rdata <= pend_vec;
        REG_EN:   reg_rdata <= en_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cic_core_chk.sv
module cic_core_chk #(
  parameter int unsigned NUM_LVL   = 16,
  parameter int unsigned FIRST_EXT = 4,
  localparam int unsigned LW       = $clog2(NUM_LVL)
) (
  input logic               clk,
  input logic               rst,
  input logic               glob_en,
  input logic               ack_valid,
  input logic [LW-1:0]      ack_level,
  input logic [NUM_LVL-1:0] rise_vec,
  input logic [NUM_LVL-1:0] set_vec,
  input logic [NUM_LVL-1:0] pend_vec,
  input logic               req_o,
  input logic [LW-1:0]      req_level_o
);
  logic [NUM_LVL-1:0] rsvd;
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_rsvd
    assign rsvd[i] = (i >= 2 && i < FIRST_EXT);
  end

  // R3
  rsvd_never_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_vec & rsvd) == '0);

  // R3
  rsvd_never_requested_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (req_level_o < LW'(2) || req_level_o >= LW'(FIRST_EXT)));

  // R2
  edge_captured_chk: assert property (@(posedge clk) disable iff (rst)
    ((rise_vec & ~rsvd) != '0) |=>
      ((pend_vec & $past(rise_vec & ~rsvd)) == $past(rise_vec & ~rsvd)));

  // R4
  reset_lvl_wins_chk: assert property (@(posedge clk) disable iff (rst)
    pend_vec[0] |=> (req_o && req_level_o == '0));

  // R6
  nmi_ignores_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_vec[1] && !pend_vec[0]) |=> (req_o && req_level_o == LW'(1)));

  // R6
  gate_blocks_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (!glob_en && pend_vec[1:0] == 2'b00) |=> !req_o);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !rise_vec[ack_level] && !set_vec[ack_level]) |=>
      !pend_vec[$past(ack_level)]);
endmodule

bind cic_core cic_core_chk #(.NUM_LVL(NUM_LVL), .FIRST_EXT(FIRST_EXT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .glob_en     (glob_en),
  .ack_valid   (ack_valid),
  .ack_level   (ack_level),
  .rise_vec    (rise_vec),
  .set_vec     (set_vec),
  .pend_vec    (pend_vec),
  .req_o       (req_o),
  .req_level_o (req_level_o)
);

// File: tb/sim_cic_core.sv
module sim_cic_core;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] irq_lines;
  logic        glob_en;
  logic        ack_valid;
  logic [3:0]  ack_level;
  logic [1:0]  reg_addr;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        req_o;
  logic [3:0]  req_level_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  cic_core u0 (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .glob_en(glob_en),
    .ack_valid(ack_valid), .ack_level(ack_level), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_o(req_o), .req_level_o(req_level_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic do_ack(logic [3:0] l);
    ack_valid = 1'b1; ack_level = l;
    tick();
    ack_valid = 1'b0;
  endtask

  task automatic chk_req(string tag, logic r, logic [3:0] l);
    chk({tag, " req"}, 32'(req_o), 32'(r));
    chk({tag, " lvl"}, 32'(req_level_o), 32'(l));
  endtask

  task automatic cleanup();
    irq_lines = '0; ack_valid = 1'b0; reg_we = 1'b0;
    tick();
    reg_wr(2'd3, 16'hFFFF);
    tick();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk_req("R1 reset", 1'b0, 4'd0);
    reg_rd(2'd0, d); chk("R1 pend", 32'(d), 32'h0);
    reg_rd(2'd1, d); chk("R1 en", 32'(d), 32'h0);
  endtask

  task automatic t_enable_rw();
    logic [15:0] d;
    reg_wr(2'd1, 16'hFFFF);
    reg_rd(2'd1, d); chk("R5 en readback", 32'(d), 32'hFFF0);
  endtask

  task automatic t_edge_prio();
    logic [15:0] d;
    irq_lines[9] = 1'b1;
    tick();
    chk_req("R8 not yet", 1'b0, 4'd0);
    tick();
    chk_req("R2 lvl9", 1'b1, 4'd9);
    reg_rd(2'd0, d); chk("R9 pend read", 32'(d), 32'h0200);
    irq_lines[5] = 1'b1;
    tick(); tick();
    chk_req("R4 lvl5 beats 9", 1'b1, 4'd5);
    do_ack(4'd5);
    chk_req("R8 ack latency", 1'b1, 4'd5);
    tick();
    chk_req("R7 back to 9", 1'b1, 4'd9);
    do_ack(4'd9);
    tick(); tick();
    chk_req("R2 held line no re-set", 1'b0, 4'd0);
    reg_rd(2'd0, d); chk("R2 pend empty", 32'(d), 32'h0);
    cleanup();
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    irq_lines[2] = 1'b1; irq_lines[3] = 1'b1;
    tick();
    reg_wr(2'd2, 16'h000C);
    tick();
    chk_req("R3 no request", 1'b0, 4'd0);
    reg_rd(2'd0, d); chk("R3 pend", 32'(d), 32'h0);
    cleanup();
  endtask

  task automatic t_mask();
    logic [15:0] d;
    reg_wr(2'd1, 16'h1000);
    irq_lines[7] = 1'b1; irq_lines[12] = 1'b1;
    tick(); tick();
    chk_req("R5 only 12 enabled", 1'b1, 4'd12);
    reg_wr(2'd1, 16'h1080);
    chk_req("R8 enable latency", 1'b1, 4'd12);
    tick();
    chk_req("R5 7 enabled", 1'b1, 4'd7);
    reg_rd(2'd0, d); chk("R5 masked still pending", 32'(d), 32'h1080);
    cleanup();
    reg_wr(2'd1, 16'hFFFF);
  endtask

  task automatic t_gate();
    glob_en = 1'b0;
    irq_lines[7] = 1'b1;
    tick(); tick();
    chk_req("R6 gated", 1'b0, 4'd0);
    irq_lines[1] = 1'b1;
    tick(); tick();
    chk_req("R6 nmi passes", 1'b1, 4'd1);
    irq_lines[0] = 1'b1;
    tick(); tick();
    chk_req("R4 reset beats nmi", 1'b1, 4'd0);
    do_ack(4'd0); tick();
    chk_req("R7 ack reset", 1'b1, 4'd1);
    do_ack(4'd1); tick();
    chk_req("R6 still gated", 1'b0, 4'd0);
    glob_en = 1'b1;
    tick();
    chk_req("R6 ungated", 1'b1, 4'd7);
    cleanup();
  endtask

  task automatic t_collide();
    logic [15:0] d;
    reg_wr(2'd2, 16'h0050);
    tick();
    chk_req("R9 sw set", 1'b1, 4'd4);
    ack_valid = 1'b1; ack_level = 4'd6; irq_lines[6] = 1'b1;
    tick();
    ack_valid = 1'b0;
    reg_rd(2'd0, d); chk("R7 edge beats ack", 32'(d), 32'h0050);
    do_ack(4'd4); tick();
    chk_req("R7 only 4 cleared", 1'b1, 4'd6);
    cleanup();
    reg_addr = 2'd3; reg_wdata = 16'h0400; reg_we = 1'b1; irq_lines[10] = 1'b1;
    tick();
    reg_we = 1'b0;
    reg_rd(2'd0, d); chk("R9 edge beats clear", 32'(d), 32'h0400);
    reg_wr(2'd3, 16'h0400);
    reg_rd(2'd0, d); chk("R9 clear", 32'(d), 32'h0);
    cleanup();
  endtask

  initial begin
    rst = 1'b1; irq_lines = '0; glob_en = 1'b1; ack_valid = 1'b0;
    ack_level = '0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable_rw();
    t_edge_prio();
    t_reserved();
    t_mask();
    t_gate();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule